// File: doc/BRIEF.md
# Prescaled Modulo Timer

This block is a register-mapped 16-bit up-counter for a 32-bit bus. Software picks a clock-source value and a power-of-two prescaler, and loads a start value and a wrap limit. While running, the counter steps once per prescaled period. When it sits at the limit, the next step reloads the start value and raises a wrap flag. The flag, gated by an enable bit, drives a level interrupt that stays high until software clears the flag.

The limit and start registers are double-buffered. Bus writes land in hidden holding registers. The live copies, which the counter uses and reads return, take the held values only while the clock-source field is zero. Writing any data to the count address does not store that data. It restarts the count from the live start value. A period of D steps is therefore set up as limit D-1 with start 0.

Top module: `pmt_timer`

## Requirements
- R1: Byte offsets are 0x00 control, 0x04 count, 0x08 limit and 0x4C start. The control fields are prescaler in bits [2:0], clock source in bits [4:3], interrupt enable in bit 6 and wrap flag in bit 7. A control read returns these fields and zeros everywhere else.
- R2: After reset, control reads 0, count reads 0, limit reads 0x0000FFFF, start reads 0, and the interrupt is low.
- R3: The count advances only while the clock-source field is 1. For the values 0, 2 and 3 it holds its value.
- R4: With prescaler field p, the count advances once every 2^p clock cycles. A write that changes the prescaler or clock-source field restarts the divider, so the first advance comes 2^p cycles after that write's clock edge.
- R5: An advance taken while the count equals the live limit loads the live start value instead of incrementing.
- R6: The wrap flag sets on every advance that loads the start value in place of the limit, and it stays set until cleared.
- R7: A control write with bit 7 = 0 clears the wrap flag, and one with bit 7 = 1 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R8: The interrupt output is high exactly while both the wrap flag and the enable bit are 1.
- R9: A write of any data to the count address loads the live start value. Such a write overrides an advance in the same cycle, and that advance does not set the flag.
- R10: Writes to the limit and start addresses go to holding registers. The live values, which reads return, copy the holding registers at each clock edge where the clock-source field is 0, and stay unchanged otherwise.
- R11: Only bits [15:0] of count, limit and start are stored, and bus reads return 0 in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the counting source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Level interrupt, flag AND enable |

## Verification
Two pairs of operations can meet in the same cycle. A wrap can coincide with a control write that clears the flag, and a wrap can coincide with a write to the count address. Both are provoked by running with prescaler 0 and a four-step period, so the edge of every wrap is known. The bench times each write with its two-negedge drive so that it lands exactly on a wrap edge. For the first pair, the flag must read set afterwards and the interrupt must stay high. For the second, the count must hold the start value and the flag must stay clear.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;
   // byte offsets decoded by software drivers
   localparam int unsigned REG_CTRL   = 'h00;
   localparam int unsigned REG_COUNT  = 'h04;
   localparam int unsigned REG_LIMIT  = 'h08;
   localparam int unsigned REG_START  = 'h4C;

   // control field positions
   localparam int unsigned B_PS   = 0;
   localparam int unsigned B_SRC  = 3;
   localparam int unsigned B_IE   = 6;
   localparam int unsigned B_FLAG = 7;

   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_SYS  = 2'd1,
      SRC_RSV2 = 2'd2,
      SRC_RSV3 = 2'd3
   } clk_src_e;
endpackage

// File: rtl/pmt_prescaler.sv
`timescale 1ns/1ps
module pmt_prescaler #(
   parameter int unsigned PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            restart,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int unsigned DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] limit;

   // 2^ps - 1 as a right-shifted mask
   assign limit = {DIV_W{1'b1}} >> (DIV_W - int'(ps));
   assign tick  = run && !restart && (div_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       div_q <= '0;
      else if (restart || !run || tick) div_q <= '0;
      else                              div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/pmt_shadow.sv
`timescale 1ns/1ps
module pmt_shadow #(
   parameter int unsigned   W        = 16,
   parameter logic [W-1:0]  RST_VAL  = '0,
   parameter bit            BUFFERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         load,
   output logic [W-1:0] value
);
   generate
      if (BUFFERED) begin : g_buffered
         logic [W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= RST_VAL;
               value  <= RST_VAL;
            end else begin
               if (wr)   hold_q <= wdata;
               if (load) value  <= hold_q;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  value <= RST_VAL;
            else if (wr) value <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/pmt_counter.sv
`timescale 1ns/1ps
module pmt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   input  logic [CNT_W-1:0] start_val,
   input  logic [CNT_W-1:0] limit_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic at_limit;

   assign at_limit = (cnt == limit_val);
   assign wrap     = tick && at_limit && !reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (reload)   cnt <= start_val;
      else if (tick)     cnt <= at_limit ? start_val : cnt + 1'b1;
   end
endmodule

// File: rtl/pmt_timer.sv
`timescale 1ns/1ps
module pmt_timer
   import pmt_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PS_W     = 3,
   parameter bit          BUFFERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam logic [CNT_W-1:0] LIMIT_RST = '1;
   localparam logic [CNT_W-1:0] START_RST = '0;

   if (CNT_W < 8 || CNT_W >= DATA_W) begin : g_bad_cnt_w
      $error("pmt_timer: CNT_W must be at least 8 and below DATA_W");
   end
   if (PS_W < 1 || PS_W > 3) begin : g_bad_ps_w
      $error("pmt_timer: PS_W must be 1 to 3");
   end
   if (ADDR_W < 7) begin : g_bad_addr_w
      $error("pmt_timer: ADDR_W too narrow for the start register offset");
   end

   logic wr_ctrl, wr_count, wr_limit, wr_start;
   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
   assign wr_count = bus_wr && (bus_addr == ADDR_W'(REG_COUNT));
   assign wr_limit = bus_wr && (bus_addr == ADDR_W'(REG_LIMIT));
   assign wr_start = bus_wr && (bus_addr == ADDR_W'(REG_START));

   logic [PS_W-1:0] ps_q, ps_new;
   clk_src_e        src_q, src_new;
   logic            ie_q, flag_q;
   logic            restart, run, load, tick, wrap;
   logic [CNT_W-1:0] cnt_q, limit_act, start_act;

   assign ps_new  = bus_wdata[B_PS +: PS_W];
   assign src_new = clk_src_e'(bus_wdata[B_SRC +: 2]);
   assign restart = wr_ctrl && ((ps_new != ps_q) || (src_new != src_q));
   assign run     = (src_q == SRC_SYS);
   assign load    = (src_q == SRC_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q  <= '0;
         src_q <= SRC_OFF;
         ie_q  <= 1'b0;
      end else if (wr_ctrl) begin
         ps_q  <= ps_new;
         src_q <= src_new;
         ie_q  <= bus_wdata[B_IE];
      end
   end

   // a wrap outranks a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             flag_q <= 1'b0;
      else if (wrap)                          flag_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[B_FLAG]) flag_q <= 1'b0;
   end

   pmt_prescaler #(.PS_W(PS_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
      .ps(ps_q), .tick(tick)
   );

   pmt_shadow #(.W(CNT_W), .RST_VAL(LIMIT_RST), .BUFFERED(BUFFERED)) u_limit (
      .clk(clk), .rst_n(rst_n), .wr(wr_limit),
      .wdata(bus_wdata[CNT_W-1:0]), .load(load), .value(limit_act)
   );

   pmt_shadow #(.W(CNT_W), .RST_VAL(START_RST), .BUFFERED(BUFFERED)) u_start (
      .clk(clk), .rst_n(rst_n), .wr(wr_start),
      .wdata(bus_wdata[CNT_W-1:0]), .load(load), .value(start_act)
   );

   pmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reload(wr_count),
      .start_val(start_act), .limit_val(limit_act), .cnt(cnt_q), .wrap(wrap)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_CTRL)) begin
         bus_rdata[B_PS +: PS_W] = ps_q;
         bus_rdata[B_SRC +: 2]   = src_q;
         bus_rdata[B_IE]         = ie_q;
         bus_rdata[B_FLAG]       = flag_q;
      end else if (bus_addr == ADDR_W'(REG_COUNT)) begin
         bus_rdata[CNT_W-1:0] = cnt_q;
      end else if (bus_addr == ADDR_W'(REG_LIMIT)) begin
         bus_rdata[CNT_W-1:0] = limit_act;
      end else if (bus_addr == ADDR_W'(REG_START)) begin
         bus_rdata[CNT_W-1:0] = start_act;
      end
   end

   assign irq = flag_q & ie_q;

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[DATA_W-1:CNT_W], bus_wdata[B_SRC+2]};
endmodule

// File: rtl/pmt_timer_chk.sv
`timescale 1ns/1ps
module pmt_timer_chk
   import pmt_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 16,
   parameter bit          BUFFERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [1:0]        src,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  limit_act,
   input logic [CNT_W-1:0]  start_act,
   input logic              flag
);
   logic cnt_wr, wrap_step;
   assign cnt_wr    = bus_wr && (bus_addr == ADDR_W'(REG_COUNT));
   assign wrap_step = tick && (cnt == limit_act) && !cnt_wr;

   assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src != 2'd1 && !cnt_wr) |=> $stable(cnt));

   assert_wrap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_step |=> (cnt == $past(start_act)));

   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_step |=> flag);

   assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(start_act)));

   assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rdata >> CNT_W) == '0));

   if (BUFFERED) begin : g_hold_chk
      assert_live_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (src != 2'd0) |=> ($stable(limit_act) && $stable(start_act)));
   end
endmodule

bind pmt_timer pmt_timer_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUFFERED(BUFFERED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .src(src_q), .tick(tick), .cnt(cnt_q),
   .limit_act(limit_act), .start_act(start_act), .flag(flag_q)
);

// File: tb/pmt_timer_test.sv
`timescale 1ns/1ps
module pmt_timer_test;
   import pmt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   pmt_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // drives at a negedge, the write lands on the next posedge, returns at the following negedge
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = 8'(a);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic peek(input int a, output logic [31:0] v);
      bus_addr = 8'(a);
      #1;
      v = bus_rdata;
   endtask

   function automatic logic [31:0] ctl(input int ps, input int src, input int ie, input int fl);
      return 32'((fl << 7) | (ie << 6) | (src << 3) | ps);
   endfunction

   task automatic sweep(input int k, input int st, input int lim);
      logic [31:0] v;
      int per;
      per = lim - st + 1;
      wr(REG_CTRL, ctl(k, 0, 1, 0));
      wr(REG_START, 32'(st));
      wr(REG_LIMIT, 32'(lim));
      wr(REG_COUNT, 32'hBEEF_0000 | 32'(k));
      peek(REG_COUNT, v);
      chk("R9 count write loads start", v, 32'(st));
      peek(REG_LIMIT, v);
      chk("R10 limit live while stopped", v, 32'(lim));
      wr(REG_CTRL, ctl(k, 1, 1, 1));
      // j = clock edges since the enabling edge
      for (int j = 0; j <= 2 * per * (1 << k) + 3; j++) begin
         if (j > 0) @(negedge clk);
         peek(REG_COUNT, v);
         chk($sformatf("R4 R5 count ps=%0d j=%0d", k, j), v,
             32'(st + ((j >> k) % per)));
         chk($sformatf("R6 R8 irq ps=%0d j=%0d", k, j), 32'(irq),
             32'(((j >> k) >= per) ? 1 : 0));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R2 reset state
      peek(REG_CTRL, v);  chk("R2 ctrl reset", v, 32'h0);
      peek(REG_COUNT, v); chk("R2 count reset", v, 32'h0);
      peek(REG_LIMIT, v); chk("R2 limit reset", v, 32'h0000_FFFF);
      peek(REG_START, v); chk("R2 start reset", v, 32'h0);
      chk("R2 irq reset", 32'(irq), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 field layout, source 2 with ps 0
      wr(REG_CTRL, 32'hFFFF_FFF0);
      peek(REG_CTRL, v); chk("R1 ctrl fields", v, 32'h0000_0050);
      // R3 source 2 does not count
      repeat (10) @(negedge clk);
      peek(REG_COUNT, v); chk("R3 source 2 holds", v, 32'h0);
      // R10 limit write held while source nonzero
      wr(REG_LIMIT, 32'h0000_0042);
      wr(REG_CTRL, 32'h0000_0058);
      peek(REG_CTRL, v); chk("R1 ctrl source 3", v, 32'h0000_0058);
      repeat (10) @(negedge clk);
      peek(REG_COUNT, v); chk("R3 source 3 holds", v, 32'h0);
      peek(REG_LIMIT, v); chk("R10 limit held", v, 32'h0000_FFFF);
      wr(REG_CTRL, ctl(0, 0, 0, 1));
      peek(REG_LIMIT, v); chk("R10 limit not yet copied", v, 32'h0000_FFFF);
      @(negedge clk);
      peek(REG_LIMIT, v); chk("R10 limit copied", v, 32'h0000_0042);
      // R11 upper bits dropped
      wr(REG_START, 32'hABCD_0003);
      wr(REG_LIMIT, 32'hFFFF_0005);
      @(negedge clk);
      peek(REG_START, v); chk("R11 start low half", v, 32'h0000_0003);
      peek(REG_LIMIT, v); chk("R11 limit low half", v, 32'h0000_0005);
      repeat (5) @(negedge clk);
      peek(REG_COUNT, v); chk("R3 source 0 holds", v, 32'h0);

      // R4 R5 R6 sweeps
      for (int ki = 0; ki < 5; ki++) begin
         int k;
         k = (ki == 4) ? 7 : ki;
         if (k == 7) sweep(k, 0, 1);
         else begin
            sweep(k, 0, 3);
            sweep(k, 2, 6);
            sweep(k, 5, 5);
         end
      end

      // same-cycle cases, ps 0, start 0, limit 3: wraps on edges E+4n
      wr(REG_CTRL, ctl(0, 0, 1, 0));
      wr(REG_START, 32'h0);
      wr(REG_LIMIT, 32'h3);
      wr(REG_COUNT, 32'h0);
      wr(REG_CTRL, ctl(0, 1, 1, 1));              // j = 0
      repeat (2) @(negedge clk);                  // j = 2
      wr(REG_CTRL, ctl(0, 1, 1, 0));              // lands E+4 with a wrap, j = 4
      chk("R7 wrap beats clear irq", 32'(irq), 32'h1);
      peek(REG_CTRL, v); chk("R7 wrap beats clear flag", 32'(v[7]), 32'h1);
      wr(REG_CTRL, ctl(0, 1, 1, 0));              // lands E+6, j = 6
      chk("R7 clear", 32'(irq), 32'h0);
      wr(REG_CTRL, ctl(0, 1, 1, 1));              // E+8 wraps, j = 8
      chk("R6 set again", 32'(irq), 32'h1);
      wr(REG_CTRL, ctl(0, 1, 0, 1));              // j = 10
      chk("R8 enable off gates irq", 32'(irq), 32'h0);
      peek(REG_CTRL, v); chk("R8 flag still set", 32'(v[7]), 32'h1);
      wr(REG_CTRL, ctl(0, 1, 1, 1));              // j = 12
      chk("R8 enable on", 32'(irq), 32'h1);
      wr(REG_CTRL, ctl(0, 1, 1, 1));              // lands E+14, j = 14
      chk("R7 bit7 one keeps flag", 32'(irq), 32'h1);
      @(negedge clk);                             // j = 15
      wr(REG_CTRL, ctl(0, 1, 1, 0));              // lands E+17, j = 17
      chk("R7 clear before reload case", 32'(irq), 32'h0);
      @(negedge clk);                             // j = 18
      wr(REG_COUNT, 32'h0000_1234);               // lands on wrap edge E+20
      chk("R9 reload suppresses flag", 32'(irq), 32'h0);
      peek(REG_COUNT, v); chk("R9 reload value", v, 32'h0);
      @(negedge clk);
      peek(REG_COUNT, v); chk("R9 counting resumes", v, 32'h1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule